// File: doc/BRIEF.md
# Bus Standby and Wake Controller

This controller sequences reset, power-down and standby for a low-pin-count host bus interface and its local data buffer. It watches the bus reset, the power-down request and the frame strobe, together with an auxiliary-power-present flag and a decoded host standby command. From these it produces a standby flag, a one-cycle buffer-clear pulse, a bus-ready flag and a one-cycle wake interrupt for the local processor. The processor's halt routine is represented only by a halt-acknowledge input.

There are two ways into standby, and each has its own wake event. The pin path starts when power-down goes low while auxiliary power is present, and it wakes on a rising edge of the bus reset. The command path starts with a host standby command, and it wakes on a falling edge of the frame strobe. In both paths the buffer contents are kept. A bus reset clears the buffer. A power-down request without auxiliary power also clears the buffer.

There are six states. S_BUSRST holds the block in reset. S_ACTIVE is normal operation. S_PIN_HALT and S_CMD_HALT wait for the halt acknowledge. S_PIN_SLEEP and S_CMD_SLEEP are the two standby states. The transitions are:
- rst_exit: S_BUSRST to S_ACTIVE.
- rst_hit: to S_BUSRST from S_ACTIVE, S_CMD_HALT or S_CMD_SLEEP.
- pd_noaux: S_ACTIVE to S_BUSRST.
- pd_aux: S_ACTIVE to S_PIN_HALT.
- cmd_req: S_ACTIVE to S_CMD_HALT.
- pin_ack: S_PIN_HALT to S_PIN_SLEEP.
- cmd_ack: S_CMD_HALT to S_CMD_SLEEP.
- pin_wake: S_PIN_SLEEP to S_ACTIVE.
- cmd_wake: S_CMD_SLEEP to S_ACTIVE.

All inputs are sampled on the rising clock edge. Every output is registered, so an output reflects the inputs sampled at the previous edge.

Top module: `standby_wake_ctrl`

## Requirements
- R1: While por_n is low, standby, bus_ready, buf_clear, wake_irq and wake_src are all 0, and the block is in S_BUSRST.
- R2: In S_ACTIVE, a low bus_rst_n causes the next edge to enter S_BUSRST. At that edge bus_ready drops and buf_clear is high for exactly one cycle. bus_ready returns one edge after bus_rst_n and pwr_dn_n are both sampled high.
- R3: In S_ACTIVE with aux_pwr=1, a low pwr_dn_n enters S_PIN_HALT with no buf_clear. standby rises only on the edge that samples halt_ack=1, and stays 0 for any number of cycles before that.
- R4: In S_ACTIVE with aux_pwr=0, a low pwr_dn_n acts as a reset: buf_clear pulses, and bus_ready stays 0 while pwr_dn_n is low.
- R5: In S_PIN_SLEEP, a low bus_rst_n and changes on pwr_dn_n are ignored: standby stays 1 and buf_clear stays 0. A rising edge of bus_rst_n (sampled 0 and then 1) gives wake_irq=1 for one cycle, with standby=0, bus_ready=1 and wake_src=0.
- R6: In S_ACTIVE, stby_cmd=1 enters S_CMD_HALT with bus_ready=0. standby rises only on the edge that samples halt_ack=1.
- R7: In S_CMD_SLEEP, a falling edge of frame_n (sampled 1 and then 0) gives wake_irq=1 for one cycle, with standby=0, bus_ready=1 and wake_src=1.
- R8: In S_PIN_SLEEP, a falling edge of frame_n does not wake the block: wake_irq stays 0 and standby stays 1.
- R9: A low bus_rst_n in S_CMD_HALT or S_CMD_SLEEP enters S_BUSRST with a buf_clear pulse and no wake_irq. Standby is never left without either wake_irq or buf_clear.
- R10: wake_irq and buf_clear are never high on two consecutive cycles, and standby and bus_ready are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_rst_n | input | 1 | Bus reset, active low |
| pwr_dn_n | input | 1 | Power-down request, active low |
| frame_n | input | 1 | Bus frame strobe, active low |
| aux_pwr | input | 1 | Auxiliary power present |
| stby_cmd | input | 1 | Decoded host standby command, one-cycle strobe |
| halt_ack | input | 1 | Local processor has halted |
| standby | output | 1 | Block is in one of the two standby states |
| bus_ready | output | 1 | Block is in S_ACTIVE |
| buf_clear | output | 1 | One-cycle request to wipe the data buffer |
| wake_irq | output | 1 | One-cycle wake interrupt to the processor |
| wake_src | output | 1 | Cause of the last wake: 0 = pin path, 1 = command path |

## Verification
The hardest situations to reach are the ones where the same input has opposite meanings depending on the entry path. A low bus reset is harmless in pin standby but destructive in command standby and in the halt wait. A frame falling edge wakes from command standby but not from pin standby.

The bench therefore sweeps both auxiliary-power settings, several halt-acknowledge delays and three command-path endings. These endings are a frame wake, a reset during standby and a reset during the halt wait. The pin path is driven through a reset-low phase and a stray frame pulse before the reset rises.

wake_src is checked after alternating pin and command wakes, so a source flag that does not update is caught.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        S_BUSRST    = 3'd0,
        S_ACTIVE    = 3'd1,
        S_PIN_HALT  = 3'd2,
        S_PIN_SLEEP = 3'd3,
        S_CMD_HALT  = 3'd4,
        S_CMD_SLEEP = 3'd5
    } sbw_state_e;

    localparam int EDGE_N   = 2;
    localparam int EDGE_RST = 0;   // bus reset, rising edge wanted
    localparam int EDGE_FRM = 1;   // frame strobe, falling edge wanted
endpackage

// File: rtl/sbw_edge.sv
module sbw_edge #(
    parameter int           W         = 2,
    parameter logic [W-1:0] RST_VAL   = '0,
    parameter logic [W-1:0] FALL_MASK = '0
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] sig,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) prev_q <= RST_VAL;
        else        prev_q <= sig;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (FALL_MASK[i]) begin : g_fall
            assign evt[i] = prev_q[i] & ~sig[i];
        end else begin : g_rise
            assign evt[i] = ~prev_q[i] & sig[i];
        end
    end
endmodule

// File: rtl/sbw_fsm.sv
module sbw_fsm
    import sbw_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       bus_rst_n,
    input  logic       pwr_dn_n,
    input  logic       aux_pwr,
    input  logic       stby_cmd,
    input  logic       halt_ack,
    input  logic       rst_rise,
    input  logic       frame_fall,
    output sbw_state_e st,
    output sbw_state_e nxt
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st <= S_BUSRST;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            S_BUSRST: begin
                if (bus_rst_n && pwr_dn_n) nxt = S_ACTIVE;               // rst_exit
            end
            S_ACTIVE: begin
                if (!bus_rst_n)     nxt = S_BUSRST;                      // rst_hit
                else if (!pwr_dn_n) nxt = aux_pwr ? S_PIN_HALT : S_BUSRST; // pd_aux / pd_noaux
                else if (stby_cmd)  nxt = S_CMD_HALT;                    // cmd_req
            end
            S_PIN_HALT: begin
                if (halt_ack) nxt = S_PIN_SLEEP;                         // pin_ack
            end
            S_PIN_SLEEP: begin
                if (rst_rise) nxt = S_ACTIVE;                            // pin_wake
            end
            S_CMD_HALT: begin
                if (!bus_rst_n)    nxt = S_BUSRST;                       // rst_hit
                else if (halt_ack) nxt = S_CMD_SLEEP;                    // cmd_ack
            end
            S_CMD_SLEEP: begin
                if (!bus_rst_n)      nxt = S_BUSRST;                     // rst_hit
                else if (frame_fall) nxt = S_ACTIVE;                     // cmd_wake
            end
            default: nxt = S_BUSRST;
        endcase
    end

    // a pin-path sleep is left only through its own wake
    AST_PIN_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!por_n)
        (st == S_PIN_SLEEP && nxt != S_PIN_SLEEP) |-> (nxt == S_ACTIVE && rst_rise)); // R5
    // frame edges never end a pin-path sleep
    AST_PIN_NO_FRAME_WAKE: assert property (@(posedge clk) disable iff (!por_n)
        (st == S_PIN_SLEEP && !rst_rise) |=> (st == S_PIN_SLEEP)); // R8
endmodule

// File: rtl/sbw_outreg.sv
module sbw_outreg
    import sbw_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  sbw_state_e st,
    input  sbw_state_e nxt,
    output logic       standby,
    output logic       bus_ready,
    output logic       buf_clear,
    output logic       wake_irq,
    output logic       wake_src
);
    logic waking;
    assign waking = (nxt == S_ACTIVE) && (st == S_PIN_SLEEP || st == S_CMD_SLEEP);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            standby   <= 1'b0;
            bus_ready <= 1'b0;
            buf_clear <= 1'b0;
            wake_irq  <= 1'b0;
            wake_src  <= 1'b0;
        end else begin
            standby   <= (nxt == S_PIN_SLEEP) || (nxt == S_CMD_SLEEP);
            bus_ready <= (nxt == S_ACTIVE);
            buf_clear <= (nxt == S_BUSRST) && (st != S_BUSRST);
            wake_irq  <= waking;
            if (waking) wake_src <= (st == S_CMD_SLEEP);
        end
    end

    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        wake_irq |=> !wake_irq); // R10
    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        buf_clear |=> !buf_clear); // R10
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
    import sbw_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic bus_rst_n,
    input  logic pwr_dn_n,
    input  logic frame_n,
    input  logic aux_pwr,
    input  logic stby_cmd,
    input  logic halt_ack,
    output logic standby,
    output logic bus_ready,
    output logic buf_clear,
    output logic wake_irq,
    output logic wake_src
);
    localparam logic [EDGE_N-1:0] EDGE_INIT = 2'b10;  // reset low, frame idle high
    localparam logic [EDGE_N-1:0] EDGE_FALL = 2'b10;  // frame uses the falling edge

    logic [EDGE_N-1:0] edge_in, edge_evt;
    sbw_state_e        st, nxt;

    assign edge_in[EDGE_RST] = bus_rst_n;
    assign edge_in[EDGE_FRM] = frame_n;

    sbw_edge #(.W(EDGE_N), .RST_VAL(EDGE_INIT), .FALL_MASK(EDGE_FALL)) edge_i (
        .clk   (clk),
        .por_n (por_n),
        .sig   (edge_in),
        .evt   (edge_evt)
    );

    sbw_fsm fsm_i (
        .clk        (clk),
        .por_n      (por_n),
        .bus_rst_n  (bus_rst_n),
        .pwr_dn_n   (pwr_dn_n),
        .aux_pwr    (aux_pwr),
        .stby_cmd   (stby_cmd),
        .halt_ack   (halt_ack),
        .rst_rise   (edge_evt[EDGE_RST]),
        .frame_fall (edge_evt[EDGE_FRM]),
        .st         (st),
        .nxt        (nxt)
    );

    sbw_outreg out_i (
        .clk       (clk),
        .por_n     (por_n),
        .st        (st),
        .nxt       (nxt),
        .standby   (standby),
        .bus_ready (bus_ready),
        .buf_clear (buf_clear),
        .wake_irq  (wake_irq),
        .wake_src  (wake_src)
    );

    AST_READY_XOR_STBY: assert property (@(posedge clk) disable iff (!por_n)
        !(standby && bus_ready)); // R10
    AST_STBY_AFTER_ACK: assert property (@(posedge clk) disable iff (!por_n)
        $rose(standby) |-> $past(halt_ack)); // R3
    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        $past(!bus_rst_n && bus_ready) |-> buf_clear); // R2
    AST_STBY_EXIT: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(standby) && !wake_irq) |-> buf_clear); // R9
    AST_WAKE_FROM_STBY: assert property (@(posedge clk) disable iff (!por_n)
        wake_irq |-> ($past(standby) && bus_ready)); // R7
endmodule

// File: tb/standby_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module standby_wake_ctrl_tb_top;
    logic clk = 1'b0;
    logic por_n, bus_rst_n, pwr_dn_n, frame_n, aux_pwr, stby_cmd, halt_ack;
    logic standby, bus_ready, buf_clear, wake_irq, wake_src;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    standby_wake_ctrl dut_i (
        .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n), .pwr_dn_n(pwr_dn_n),
        .frame_n(frame_n), .aux_pwr(aux_pwr), .stby_cmd(stby_cmd), .halt_ack(halt_ack),
        .standby(standby), .bus_ready(bus_ready), .buf_clear(buf_clear),
        .wake_irq(wake_irq), .wake_src(wake_src)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // expected output vector: standby, bus_ready, buf_clear, wake_irq
    task automatic chk4(input string req, input logic s, input logic r, input logic c, input logic w);
        chk(req, "standby",   standby,   s);
        chk(req, "bus_ready", bus_ready, r);
        chk(req, "buf_clear", buf_clear, c);
        chk(req, "wake_irq",  wake_irq,  w);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        por_n = 1'b0; bus_rst_n = 1'b0; pwr_dn_n = 1'b1; frame_n = 1'b1;
        aux_pwr = 1'b1; stby_cmd = 1'b0; halt_ack = 1'b0;
        repeat (3) step();
        chk4("R1", 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1", "wake_src", wake_src, 1'b0);
        por_n = 1'b1;
        step();
        chk4("R2", 1'b0, 1'b0, 1'b0, 1'b0);        // still held by bus reset
        bus_rst_n = 1'b1;
        step();
        chk4("R2", 1'b0, 1'b1, 1'b0, 1'b0);
        // plain bus reset from active
        bus_rst_n = 1'b0;
        step(); chk4("R2", 1'b0, 1'b0, 1'b1, 1'b0);
        step(); chk4("R2", 1'b0, 1'b0, 1'b0, 1'b0);
        bus_rst_n = 1'b1;
        step(); chk4("R2", 1'b0, 1'b1, 1'b0, 1'b0);

        for (int aux = 0; aux < 2; aux++) begin
            for (int dly = 0; dly < 4; dly++) begin
                aux_pwr = aux[0];
                // ---- pin path ----
                pwr_dn_n = 1'b0;
                step();
                if (aux == 0) begin
                    chk4("R4", 1'b0, 1'b0, 1'b1, 1'b0);
                    step(); chk4("R4", 1'b0, 1'b0, 1'b0, 1'b0);
                    pwr_dn_n = 1'b1;
                    step(); chk4("R4", 1'b0, 1'b1, 1'b0, 1'b0);
                end else begin
                    chk4("R3", 1'b0, 1'b0, 1'b0, 1'b0);
                    for (int k = 0; k < dly; k++) begin
                        step(); chk4("R3", 1'b0, 1'b0, 1'b0, 1'b0);
                    end
                    halt_ack = 1'b1;
                    step(); chk4("R3", 1'b1, 1'b0, 1'b0, 1'b0);
                    halt_ack = 1'b0;
                    bus_rst_n = 1'b0;
                    step(); chk4("R5", 1'b1, 1'b0, 1'b0, 1'b0);
                    frame_n = 1'b0;
                    step(); chk4("R8", 1'b1, 1'b0, 1'b0, 1'b0);
                    frame_n = 1'b1;
                    for (int k = 0; k <= dly; k++) begin
                        step(); chk4("R8", 1'b1, 1'b0, 1'b0, 1'b0);
                    end
                    pwr_dn_n = 1'b1;
                    step(); chk4("R5", 1'b1, 1'b0, 1'b0, 1'b0);
                    bus_rst_n = 1'b1;
                    step(); chk4("R5", 1'b0, 1'b1, 1'b0, 1'b1);
                    chk("R5", "wake_src", wake_src, 1'b0);
                    step(); chk4("R10", 1'b0, 1'b1, 1'b0, 1'b0);
                end
                // ---- command path, three endings ----
                for (int v = 0; v < 3; v++) begin
                    stby_cmd = 1'b1;
                    step(); stby_cmd = 1'b0;
                    chk4("R6", 1'b0, 1'b0, 1'b0, 1'b0);
                    for (int k = 0; k < dly; k++) begin
                        step(); chk4("R6", 1'b0, 1'b0, 1'b0, 1'b0);
                    end
                    if (v == 2) begin
                        bus_rst_n = 1'b0;
                        step(); chk4("R9", 1'b0, 1'b0, 1'b1, 1'b0);
                    end else begin
                        halt_ack = 1'b1;
                        step(); chk4("R6", 1'b1, 1'b0, 1'b0, 1'b0);
                        halt_ack = 1'b0;
                        for (int k = 0; k <= dly; k++) begin
                            step(); chk4("R7", 1'b1, 1'b0, 1'b0, 1'b0);
                        end
                        if (v == 0) begin
                            frame_n = 1'b0;
                            step(); chk4("R7", 1'b0, 1'b1, 1'b0, 1'b1);
                            chk("R7", "wake_src", wake_src, 1'b1);
                            frame_n = 1'b1;
                            step(); chk4("R10", 1'b0, 1'b1, 1'b0, 1'b0);
                        end else begin
                            bus_rst_n = 1'b0;
                            step(); chk4("R9", 1'b0, 1'b0, 1'b1, 1'b0);
                        end
                    end
                    if (v != 0) begin
                        step(); chk4("R10", 1'b0, 1'b0, 1'b0, 1'b0);
                        bus_rst_n = 1'b1;
                        step(); chk4("R2", 1'b0, 1'b1, 1'b0, 1'b0);
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule